// File: doc/BRIEF.md
# Camera Pixel Word Packer

This block takes a pipelined camera pixel stream and turns it into 32-bit words for an output FIFO link. The camera runs in single-byte tap mode. Each pixel is qualified by a pixel strobe and a data-valid flag, and the block reads only the lowest byte of the pixel bus. Four consecutive pixels make up one word, and the oldest pixel sits in the lowest lane. A frame-end flag on the final pixel closes a partly filled word early. The unused upper lanes of that word are zero.

Completed words go into a 512-word buffer FIFO. From there they are moved, one per cycle, to whichever of six output channels a one-hot select input names. The move happens only while the selected channel reports that it is not full. The camera cannot be held back. When the buffer is full, newly completed words are thrown away, and a saturating counter records how many were lost.

The packer is a four-state machine whose state names the next lane to fill:
- LANE0 moves to LANE1, LANE1 to LANE2, and LANE2 to LANE3 on each accepted pixel that is not marked last.
- From LANE3, an accepted pixel emits a word and returns to LANE0.
- From any state, an accepted pixel marked last emits a word and returns to LANE0.
- A cycle without an accepted pixel stays in the current state.
- Reset forces LANE0.

Top module: `pix_word_packer`

## Requirements
- R1: A pixel is accepted only on a clock edge where both `pix_strobe` and `pix_valid` are high. Other cycles leave the packer state and its output unchanged.
- R2: Only `pix_data[7:0]` carries pixel data. The upper bytes of the bus have no effect on any output word.
- R3: Four accepted pixels form one word. The first pixel goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24. The word is offered to the buffer in the cycle after the fourth pixel is accepted.
- R4: An accepted pixel with `pix_last` high completes the current word at once, with zeros in the lanes above it. The next accepted pixel starts again in bits 7:0.
- R5: The buffer holds 512 words. While it is not empty and a channel can be written, `out_data` presents the oldest word and one word leaves per cycle, in the order the words were written.
- R6: Bit i of `chan_sel` and of `out_wr` refers to channel i. `out_wr` is either zero or equal to `chan_sel`. When `chan_sel` is zero or has two or more bits set, `out_wr` stays zero and the buffer keeps its words.
- R7: A word offered while the buffer holds 512 words is discarded and `drop_count` increases by one. Fullness is judged before any read in the same cycle.
- R8: `drop_count` stops at 65535. A synchronous `rst` clears the counter, empties the buffer and returns the packer to lane 0.
- R9: While the selected channel's bit of `out_full` is high, nothing is written to it. No word is lost as long as the buffer has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_strobe | input | 1 | Pixel strobe |
| pix_valid | input | 1 | Data valid qualifier |
| pix_last | input | 1 | Marks the final pixel of a frame |
| pix_data | input | 24 | Pixel bus; only bits 7:0 are used |
| chan_sel | input | 6 | One-hot output channel select |
| out_full | input | 6 | Full flag of each output channel |
| out_wr | output | 6 | Write strobe per output channel |
| out_data | output | 32 | Word presented to the output channels |
| drop_count | output | 16 | Saturating count of discarded words |

## Verification
The bench runs a behavioural queue model alongside the design and checks the outputs every cycle.

Lane order and the strobe and valid qualifiers are exercised with random upper bytes. A design that swapped lanes, read an upper byte, or accepted a pixel on strobe alone would show wrong `out_data`.

Frames ending after one, two and three pixels check zero padding and the return to lane 0. Missing padding would leak stale bytes, and a missed restart would shift the next word.

Zero and multi-bit channel selects, and full flags toggled in the middle of a drain, catch writes to a wrong or full channel. Filling the buffer past 512 words and then past 65535 drops shows whether the boundary is off by one and whether the counter wraps. A mid-run reset must leave the counter and the buffer empty.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
    localparam int PIX_W  = 8;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / PIX_W;

    typedef enum logic [1:0] {
        LANE0 = 2'd0,
        LANE1 = 2'd1,
        LANE2 = 2'd2,
        LANE3 = 2'd3
    } lane_state_t;
endpackage

// File: rtl/pwp_lane_packer.sv
module pwp_lane_packer
    import pwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              last,
    input  logic [PIX_W-1:0]  pix,
    output logic [WORD_W-1:0] word_o,
    output logic              word_v
);
    lane_state_t       st_q, st_n;
    logic [WORD_W-1:0] acc_q, acc_n;
    logic [WORD_W-1:0] merged;
    logic              emit;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LANE0;
            acc_q  <= '0;
            word_v <= 1'b0;
            word_o <= '0;
        end else begin
            st_q   <= st_n;
            acc_q  <= acc_n;
            word_v <= emit;
            if (emit) word_o <= merged;
        end
    end

    assign merged = acc_q | ({{(WORD_W-PIX_W){1'b0}}, pix} << (PIX_W * int'(st_q)));

    // next state and outputs
    always_comb begin
        st_n  = st_q;
        acc_n = acc_q;
        emit  = 1'b0;
        if (take) begin
            unique case (st_q)
                LANE0: st_n = LANE1;
                LANE1: st_n = LANE2;
                LANE2: st_n = LANE3;
                LANE3: st_n = LANE0;
            endcase
            if (st_q == LANE3 || last) begin
                emit  = 1'b1;
                acc_n = '0;
                st_n  = LANE0;
            end else begin
                acc_n = merged;
            end
        end
    end
endmodule

// File: rtl/pwp_buf.sv
module pwp_buf #(
    parameter int DEPTH = 512,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          wr_ok, rd_ok;

    assign full  = (cnt == (AW+1)'(DEPTH));
    assign empty = (cnt == '0);
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= wp + 1'b1;
            if (rd_ok) rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
        end
    end
endmodule

// File: rtl/pwp_steer.sv
module pwp_steer #(
    parameter int NCH = 6,
    parameter int W   = 32
) (
    input  logic           empty,
    input  logic [W-1:0]   head,
    input  logic [NCH-1:0] chan_sel,
    input  logic [NCH-1:0] out_full,
    output logic           pop,
    output logic [NCH-1:0] out_wr,
    output logic [W-1:0]   out_data
);
    logic sel_ok, sel_full;

    assign sel_ok   = (chan_sel != '0) && ((chan_sel & (chan_sel - 1'b1)) == '0);
    assign sel_full = |(chan_sel & out_full);
    assign pop      = !empty && sel_ok && !sel_full;
    assign out_data = head;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign out_wr[i] = pop && chan_sel[i];
    end
endmodule

// File: rtl/pwp_drop_ctr.sv
module pwp_drop_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)                     count <= '0;
        else if (hit && count != '1) count <= count + 1'b1;
    end
endmodule

// File: rtl/pix_word_packer.sv
module pix_word_packer
    import pwp_pkg::*;
#(
    parameter int BUS_W = 24,
    parameter int NCH   = 6,
    parameter int DEPTH = 512,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_strobe,
    input  logic              pix_valid,
    input  logic              pix_last,
    input  logic [BUS_W-1:0]  pix_data,
    input  logic [NCH-1:0]    chan_sel,
    input  logic [NCH-1:0]    out_full,
    output logic [NCH-1:0]    out_wr,
    output logic [WORD_W-1:0] out_data,
    output logic [CNT_W-1:0]  drop_count
);
    logic [WORD_W-1:0] pk_word, head;
    logic              pk_v, pop, full, empty;

    pwp_lane_packer u_pack (
        .clk(clk), .rst(rst),
        .take(pix_strobe && pix_valid),
        .last(pix_last),
        .pix(pix_data[PIX_W-1:0]),
        .word_o(pk_word), .word_v(pk_v)
    );

    pwp_buf #(.DEPTH(DEPTH), .W(WORD_W)) u_buf (
        .clk(clk), .rst(rst),
        .wr(pk_v), .wdata(pk_word),
        .rd(pop), .rdata(head),
        .full(full), .empty(empty)
    );

    pwp_steer #(.NCH(NCH), .W(WORD_W)) u_steer (
        .empty(empty), .head(head),
        .chan_sel(chan_sel), .out_full(out_full),
        .pop(pop), .out_wr(out_wr), .out_data(out_data)
    );

    pwp_drop_ctr #(.W(CNT_W)) u_drop (
        .clk(clk), .rst(rst),
        .hit(pk_v && full),
        .count(drop_count)
    );
endmodule

// File: rtl/pwp_checker.sv
module pwp_checker #(
    parameter int BUS_W = 24,
    parameter int NCH   = 6,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_strobe,
    input logic             pix_valid,
    input logic [BUS_W-1:0] pix_data,
    input logic [NCH-1:0]   chan_sel,
    input logic [NCH-1:0]   out_full,
    input logic [NCH-1:0]   out_wr,
    input logic [CNT_W-1:0] drop_count
);
    p_wr_matches_sel_r6: assert property (@(posedge clk) disable iff (rst)
        (out_wr != '0) |-> (out_wr == chan_sel));

    p_bad_sel_silent_r6: assert property (@(posedge clk) disable iff (rst)
        !$onehot(chan_sel) |-> (out_wr == '0));

    p_no_write_full_r9: assert property (@(posedge clk) disable iff (rst)
        (out_wr != '0) |-> ((out_wr & out_full) == '0));

    p_count_monotone_r7: assert property (@(posedge clk) disable iff (rst)
        (drop_count != '0) |=> (drop_count >= $past(drop_count)));

    p_count_saturates_r8: assert property (@(posedge clk) disable iff (rst)
        (drop_count == '1) |=> (drop_count == '1));

    p_known_pixel_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_strobe && pix_valid) |-> !$isunknown(pix_data[7:0]));
endmodule

bind pix_word_packer pwp_checker #(.BUS_W(BUS_W), .NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .pix_strobe(pix_strobe), .pix_valid(pix_valid),
    .pix_data(pix_data), .chan_sel(chan_sel), .out_full(out_full),
    .out_wr(out_wr), .drop_count(drop_count)
);

// File: tb/pix_word_packer_tb.sv
`timescale 1ns/1ps
module pix_word_packer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_strobe = 1'b0, pix_valid = 1'b0, pix_last = 1'b0;
    logic [23:0] pix_data = '0;
    logic [5:0]  chan_sel = 6'b000001, out_full = '0;
    logic [5:0]  out_wr;
    logic [31:0] out_data;
    logic [15:0] drop_count;

    always #10 clk = ~clk;

    pix_word_packer u_dut (
        .clk(clk), .rst(rst), .pix_strobe(pix_strobe), .pix_valid(pix_valid),
        .pix_last(pix_last), .pix_data(pix_data), .chan_sel(chan_sel),
        .out_full(out_full), .out_wr(out_wr), .out_data(out_data),
        .drop_count(drop_count)
    );

    int    vectors = 0, misses = 0;
    bit    chk_en = 0, done = 0;
    string cur_req = "R8";

    int          m_lane;
    logic [31:0] m_acc, m_word;
    bit          m_pend;
    int          m_drop;
    logic [31:0] q[$];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic bit can_rd();
        return q.size() > 0 && $onehot(chan_sel) && ((chan_sel & out_full) == 0);
    endfunction

    // reference model, advanced on every clock edge
    always @(posedge clk) begin
        if (rst) begin
            m_lane = 0; m_acc = 0; m_pend = 0; m_drop = 0; q.delete();
        end else begin
            bit full_now;
            full_now = (q.size() >= 512);
            if (can_rd()) void'(q.pop_front());
            if (m_pend) begin
                if (full_now) begin
                    if (m_drop < 65535) m_drop++;
                end else q.push_back(m_word);
            end
            m_pend = 0;
            if (pix_strobe && pix_valid) begin
                logic [31:0] mg;
                mg = m_acc | ({24'd0, pix_data[7:0]} << (8 * m_lane));
                if (m_lane == 3 || pix_last) begin
                    m_word = mg; m_pend = 1; m_acc = 0; m_lane = 0;
                end else begin
                    m_acc = mg; m_lane++;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            bit r;
            r = can_rd();
            chk({cur_req, " out_wr"}, {26'd0, out_wr}, r ? {26'd0, chan_sel} : 32'd0);
            if (r) chk({cur_req, " out_data"}, out_data, q[0]);
            chk({cur_req, " drop_count"}, {16'd0, drop_count}, m_drop[31:0]);
        end
    end

    task automatic drive(bit s, bit v, bit l, logic [7:0] b);
        @(posedge clk); #4;
        pix_strobe = s; pix_valid = v; pix_last = l;
        pix_data = {$urandom_range(0, 65535), b};
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00);
    endtask

    initial begin
        #(20 * 195000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #4 rst = 1'b0;
        @(negedge clk);
        cur_req = "R8";
        chk("R8 reset out_wr", {26'd0, out_wr}, 32'd0);
        chk("R8 reset drop_count", {16'd0, drop_count}, 32'd0);
        chk_en = 1;

        cur_req = "R3";               // plain lane order, random upper bytes (R2)
        for (int i = 0; i < 16; i++) drive(1, 1, 0, 8'(8'h10 + i));
        idle(4);

        cur_req = "R1";               // qualifier gaps
        for (int i = 0; i < 24; i++) drive(i % 3 != 1, i % 4 != 2, 0, 8'(8'h40 + i));
        idle(4);

        cur_req = "R2";
        for (int i = 0; i < 8; i++) drive(1, 1, 0, 8'(8'hA0 + i));
        idle(3);

        cur_req = "R4";               // frames ending after 1, 2 and 3 pixels
        for (int n = 1; n <= 3; n++) begin
            for (int i = 0; i < n; i++) drive(1, 1, i == n - 1, 8'(8'hC0 + 16 * n + i));
            idle(1);
        end
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 8'(8'hE0 + i));
        idle(3);

        cur_req = "R6";               // zero and multi-bit selects hold the buffer
        @(posedge clk); #4 chan_sel = 6'b000000;
        for (int i = 0; i < 8; i++) drive(1, 1, 0, 8'(i));
        idle(3);
        @(posedge clk); #4 chan_sel = 6'b100100;
        idle(4);
        @(posedge clk); #4 chan_sel = 6'b100000;
        idle(6);

        cur_req = "R9";               // full flag toggled during drain
        @(posedge clk); #4 chan_sel = 6'b000100;
        for (int i = 0; i < 40; i++) begin
            drive(1, 1, (i % 5) == 4, 8'(i * 7));
            out_full = (i % 3 == 0) ? 6'b000100 : 6'b010000;
        end
        @(posedge clk); #4 out_full = '0;
        idle(20);

        cur_req = "R7";               // overflow of the 512-word buffer
        @(posedge clk); #4 out_full = 6'b111111;
        for (int i = 0; i < 600; i++) drive(1, 1, 1, 8'(i));
        idle(4);
        chk("R7 drops after 600 words", {16'd0, drop_count}, 32'd88);

        cur_req = "R5";               // drain the full buffer in order
        @(posedge clk); #4 out_full = '0; chan_sel = 6'b000010;
        idle(530);

        cur_req = "R8";               // saturation
        @(posedge clk); #4 out_full = 6'b000010;
        for (int i = 0; i < 66000; i++) drive(1, 1, 1, 8'(i));
        idle(4);
        chk("R8 saturated count", {16'd0, drop_count}, 32'd65535);

        @(posedge clk); #4 rst = 1'b1;   // mid-run reset with a full buffer
        @(posedge clk); #4 rst = 1'b0; out_full = '0;
        @(negedge clk);
        chk("R8 count after reset", {16'd0, drop_count}, 32'd0);
        chk("R8 buffer empty after reset", {26'd0, out_wr}, 32'd0);
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 8'(8'h55 + i));
        idle(4);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule